// File: doc/BRIEF.md
# Warp Memory Request Coalescer

This block takes one memory request issued by a whole warp and turns it into the shortest list of aligned burst transactions that covers every active lane. The request carries one byte address per lane and an active mask. Lanes whose addresses land in the same aligned burst window share one transaction. A unit-stride pattern of 4-byte elements therefore collapses into a handful of bursts, while strided or scattered patterns need more.

The request side is a valid/ready stream. The block raises `req_ready` only while idle and takes a request on the cycle both `req_valid` and `req_ready` are high. It then presents one burst at a time on the burst stream. Each burst carries its aligned address and the mask of lanes it serves. The consumer may hold `bst_ready` low for any number of cycles. While it does, the offered burst stays exactly as it is, and a burst counts as issued only on a handshake. When the last burst has been taken, `done` pulses for one cycle and `txn_count` shows how many bursts the request needed. A request with no active lane produces no bursts and finishes right away.

Top module: `warp_coalescer`

## Requirements
- R1: While reset is held and on the first cycle after it, `req_ready` is 1, `bst_valid` is 0, `done` is 0 and `txn_count` is 0.
- R2: A request is taken on a cycle with `req_valid` and `req_ready` both high. From the next cycle until the cycle in which `done` is high, `req_ready` stays 0.
- R3: Burst windows are 64 bytes and start at multiples of 64. `bst_addr` is a lane address with its low 6 bits cleared.
- R4: Each burst is the window of the lowest-numbered active lane that has not yet been served.
- R5: `bst_lanes` (bit i stands for lane i) holds exactly the unserved active lanes whose address lies in the offered window. Every active lane is served by exactly one burst.
- R6: Lanes whose bit in `req_mask` is 0 never appear in `bst_lanes` and never cause a burst.
- R7: A request with an all-zero mask produces no burst. `done` is high on the cycle after acceptance, with `txn_count` equal to 0.
- R8: While a request is pending, `bst_valid` is 1. While `bst_ready` is 0, `bst_addr` and `bst_lanes` hold their values, and a burst is consumed only on a handshake.
- R9: `done` is high for exactly one cycle, the cycle after the final burst handshake. `txn_count` then equals the number of distinct 64-byte windows touched by active lanes, and it holds that value until the next `done`.
- R10: With 64 lanes at 4-byte stride starting on a 64-byte boundary, the request takes 4 bursts. Starting 4 bytes past a boundary, it takes 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | LANES*ADDR_W | Byte address per lane; lane i at bits [i*ADDR_W +: ADDR_W] |
| req_mask | input | LANES | Active lanes of the request |
| bst_valid | output | 1 | Burst offered |
| bst_ready | input | 1 | Consumer takes the offered burst |
| bst_addr | output | ADDR_W | Aligned burst start address |
| bst_lanes | output | LANES | Lanes served by the offered burst |
| done | output | 1 | One-cycle pulse when a request is finished |
| txn_count | output | $clog2(LANES+1) | Burst count of the last finished request |

## Verification
The assertions assume that requests arrive only through the handshake, and that `req_addr` and `req_mask` matter only on the accepting cycle. They also assume that `bst_ready` may change freely from cycle to cycle. The bench drives request fields only together with `req_valid`, and only after it has seen `req_ready` high. It varies `bst_ready` in steady, alternating and one-in-three patterns. It sweeps element strides from 0 to 33 at aligned and unaligned bases. It also drives sparse masks and scattered addresses, including inactive lanes that point at windows no active lane uses.

// File: rtl/coal_pkg.sv
package coal_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } coal_state_e;
endpackage

// File: rtl/lane_pick.sv
// Lowest-numbered set bit of the pending vector.
module lane_pick #(
  parameter int LANES  = 64,
  parameter int LANE_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LANES-1:0]  pend,
  output logic              any,
  output logic [LANE_W-1:0] idx
);
  always_comb begin
    idx = '0;
    any = |pend;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (pend[i]) idx = LANE_W'(i);
    end
  end

  // R4
  lowest_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> (pend[idx] && ((pend & ((LANES'(1) << idx) - LANES'(1))) == '0)));
endmodule

// File: rtl/tag_match.sv
// Per-lane compare of the window tag against the reference window.
module tag_match #(
  parameter int LANES  = 64,
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 6,
  localparam int TAG_W = ADDR_W - OFF_W
) (
  input  logic [LANES*ADDR_W-1:0] addr_flat,
  input  logic [LANES-1:0]        pend,
  input  logic [TAG_W-1:0]        ref_tag,
  output logic [LANES-1:0]        hit
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign hit[g] = pend[g] && (addr_flat[g*ADDR_W+OFF_W +: TAG_W] == ref_tag);
  end
endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer
  import coal_pkg::*;
#(
  parameter int LANES       = 64,
  parameter int ADDR_W      = 32,
  parameter int BURST_BYTES = 64,
  localparam int OFF_W  = $clog2(BURST_BYTES),
  localparam int TAG_W  = ADDR_W - OFF_W,
  localparam int LANE_W = $clog2(LANES),
  localparam int CNT_W  = $clog2(LANES + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [LANES*ADDR_W-1:0] req_addr,
  input  logic [LANES-1:0]        req_mask,
  output logic                    bst_valid,
  input  logic                    bst_ready,
  output logic [ADDR_W-1:0]       bst_addr,
  output logic [LANES-1:0]        bst_lanes,
  output logic                    done,
  output logic [CNT_W-1:0]        txn_count
);
  coal_state_e             state_q;
  logic [LANES*ADDR_W-1:0] addr_q;
  logic [LANES-1:0]        mask_q;
  logic [LANES-1:0]        pend_q;
  logic [CNT_W-1:0]        cnt_q;
  logic [CNT_W-1:0]        txn_q;
  logic                    done_q;

  logic                    pick_any;
  logic [LANE_W-1:0]       pick_idx;
  logic [TAG_W-1:0]        ref_tag;
  logic [LANES-1:0]        hit;
  logic [LANES-1:0]        remain;
  logic                    take_req;
  logic                    take_bst;

  lane_pick #(.LANES(LANES), .LANE_W(LANE_W)) u_pick (
    .clk  (clk),
    .rst_n(rst_n),
    .pend (pend_q),
    .any  (pick_any),
    .idx  (pick_idx)
  );

  assign ref_tag = addr_q[int'(pick_idx)*ADDR_W+OFF_W +: TAG_W];

  tag_match #(.LANES(LANES), .ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_match (
    .addr_flat(addr_q),
    .pend     (pend_q),
    .ref_tag  (ref_tag),
    .hit      (hit)
  );

  assign remain    = pend_q & ~hit;
  assign req_ready = (state_q == ST_IDLE);
  assign bst_valid = (state_q == ST_RUN) && pick_any;
  assign bst_addr  = {ref_tag, {OFF_W{1'b0}}};
  assign bst_lanes = hit;
  assign done      = done_q;
  assign txn_count = txn_q;
  assign take_req  = req_valid && req_ready;
  assign take_bst  = bst_valid && bst_ready;

  always_ff @(posedge clk) begin
    if (take_req) addr_q <= req_addr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mask_q  <= '0;
      pend_q  <= '0;
      cnt_q   <= '0;
      txn_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (take_req) begin
            mask_q <= req_mask;
            pend_q <= req_mask;
            cnt_q  <= '0;
            if (req_mask == '0) begin
              done_q <= 1'b1;
              txn_q  <= '0;
            end else begin
              state_q <= ST_RUN;
            end
          end
        end
        ST_RUN: begin
          if (take_bst) begin
            pend_q <= remain;
            cnt_q  <= cnt_q + CNT_W'(1);
            if (remain == '0) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
              txn_q   <= cnt_q + CNT_W'(1);
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R6
  inactive_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bst_valid |-> ((bst_lanes & ~mask_q) == '0));

  // R5
  served_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bst_valid |-> (bst_lanes != '0));

  // R8
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bst_valid && !bst_ready) |=> (bst_valid && $stable(bst_addr) && $stable(bst_lanes)));

  // R7
  empty_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (req_mask == '0)) |=> (done && (txn_count == '0) && !bst_valid));

  // R9
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (txn_count <= CNT_W'(LANES)));

  // R2
  busy_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bst_valid |-> !req_ready);
endmodule

// File: tb/test_warp_coalescer.sv
module test_warp_coalescer;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 64;
  localparam int AW = 32;
  localparam int CW = $clog2(LANES + 1);
  localparam int WDOG = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [LANES*AW-1:0] req_addr = '0;
  logic [LANES-1:0] req_mask = '0;
  logic bst_valid;
  logic bst_ready = 1'b0;
  logic [AW-1:0] bst_addr;
  logic [LANES-1:0] bst_lanes;
  logic done;
  logic [CW-1:0] txn_count;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  logic [AW-1:0] la [LANES];
  logic [LANES-1:0] lm;
  logic [31:0] seed = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  warp_coalescer #(.LANES(LANES), .ADDR_W(AW), .BURST_BYTES(64)) i_warp_coalescer (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_mask(req_mask),
    .bst_valid(bst_valid), .bst_ready(bst_ready),
    .bst_addr(bst_addr), .bst_lanes(bst_lanes),
    .done(done), .txn_count(txn_count)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WDOG) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run hung, actual=%0d expected<%0d cycles", cyc, WDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  function automatic int distinct_windows();
    int d = 0;
    for (int i = 0; i < LANES; i++) begin
      bit seen = 0;
      if (lm[i]) begin
        for (int j = 0; j < i; j++)
          if (lm[j] && ((la[j] >> 6) == (la[i] >> 6))) seen = 1;
        if (!seen) d++;
      end
    end
    return d;
  endfunction

  // mode 0: always ready, 1: every other cycle, 2: one cycle in three
  task automatic run(input int mode);
    logic [LANES-1:0] pend;
    logic [AW-1:0] ea;
    logic [LANES-1:0] el;
    int cnt = 0;
    int k = 0;
    int lo;
    int d;
    bit fin = 0;
    d = distinct_windows();
    @(negedge clk);
    chk(req_ready == 1'b1, "R2", "ready before request", req_ready, 1);
    for (int i = 0; i < LANES; i++) req_addr[i*AW +: AW] = la[i];
    req_mask = lm;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    pend = lm;
    while (!fin) begin
      bst_ready = 1'b0;
      if (done) begin
        fin = 1;
        chk(pend == '0, "R5", "lanes left unserved at done", pend, 0);
      end else begin
        chk(req_ready == 1'b0, "R2", "ready while busy", req_ready, 0);
        chk(bst_valid == 1'b1, "R8", "valid while pending", bst_valid, 1);
        lo = 0;
        for (int i = LANES - 1; i >= 0; i--) if (pend[i]) lo = i;
        ea = la[lo] & ~32'h3f;
        el = '0;
        for (int i = 0; i < LANES; i++)
          if (pend[i] && ((la[i] & ~32'h3f) == ea)) el[i] = 1'b1;
        chk(bst_addr == ea, "R3 R4", "burst address", bst_addr, ea);
        chk(bst_lanes == el, "R5", "served lanes", bst_lanes, el);
        chk((bst_lanes & ~lm) == '0, "R6", "inactive lane served", bst_lanes & ~lm, 0);
        case (mode)
          0: bst_ready = 1'b1;
          1: bst_ready = (k % 2) == 1;
          default: bst_ready = (k % 3) == 2;
        endcase
        if (bst_ready) begin
          pend = pend & ~el;
          cnt++;
        end
        k++;
        @(negedge clk);
      end
    end
    bst_ready = 1'b0;
    if (lm == '0) chk(k == 0, "R7", "cycles to done on empty mask", k, 0);
    chk(int'(txn_count) == cnt, "R9", "count vs handshakes", txn_count, cnt);
    chk(int'(txn_count) == d, "R9", "count vs distinct windows", txn_count, d);
    @(negedge clk);
    chk(done == 1'b0, "R9", "done longer than one cycle", done, 0);
    chk(int'(txn_count) == d, "R9", "count not held", txn_count, d);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R1", "reset req_ready", req_ready, 1);
    chk(bst_valid == 1'b0, "R1", "reset bst_valid", bst_valid, 0);
    chk(done == 1'b0, "R1", "reset done", done, 0);
    chk(txn_count == '0, "R1", "reset txn_count", txn_count, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && bst_valid == 1'b0, "R1", "after reset idle",
        {req_ready, bst_valid}, 2'b10);

    // R10 unit stride, aligned and unaligned base
    lm = '1;
    for (int i = 0; i < LANES; i++) la[i] = 32'h1000 + i * 4;
    run(0);
    chk(txn_count == CW'(4), "R10", "aligned unit stride", txn_count, 4);
    for (int i = 0; i < LANES; i++) la[i] = 32'h1004 + i * 4;
    run(1);
    chk(txn_count == CW'(5), "R10", "unaligned unit stride", txn_count, 5);

    // R7 empty mask, twice in a row
    lm = '0;
    run(0);
    run(2);

    // stride sweep with varied back-pressure (R3 R4 R5 R8 R9)
    for (int s = 0; s < 34; s++) begin
      for (int o = 0; o < 4; o++) begin
        int offs;
        offs = (o == 0) ? 0 : (o == 1) ? 4 : (o == 2) ? 60 : 200;
        lm = '1;
        for (int i = 0; i < LANES; i++) la[i] = 32'h2000 + offs + i * s * 4;
        run((s + o) % 3);
      end
    end

    // R6 sparse masks, inactive lanes pointing at private windows
    for (int p = 0; p < 6; p++) begin
      case (p)
        0: lm = 64'h8000_0000_0000_0000;
        1: lm = 64'h5555_5555_5555_5555;
        2: lm = 64'hffff_ffff_0000_0000;
        3: lm = 64'h0000_0000_0000_0001;
        4: lm = 64'h8421_0842_1084_2108;
        default: lm = 64'h00ff_0000_ff00_00f0;
      endcase
      for (int i = 0; i < LANES; i++)
        la[i] = lm[i] ? (32'h4000 + i * 8) : (32'h9000_0000 + i * 64);
      run(p % 3);
    end

    // scattered addresses and masks
    for (int r = 0; r < 40; r++) begin
      seed = nxt(seed);
      lm[31:0] = seed;
      seed = nxt(seed);
      lm[63:32] = seed;
      for (int i = 0; i < LANES; i++) begin
        seed = nxt(seed);
        la[i] = {22'h0, seed[9:0]} & ~32'h3;
      end
      run(r % 3);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule